// File: doc/BRIEF.md
# Depth-Tested Rectangle Fill Engine

This engine paints an axis-aligned, inclusive rectangle of pixels with one constant 32-bit RGBA value. Every pixel also carries one constant 32-bit depth. The engine shares a single-port memory with its surroundings. The colour surface and the depth surface live in two regions of that memory, and each region starts at a base pointer counted in 2048-byte units. Both regions use a linear, row-major layout with one 32-bit word per pixel.

For each covered pixel the engine reads the stored depth and compares the incoming depth against it in the configured mode. When the pixel passes, the engine writes the colour and, unless depth updates are masked, the new depth. A pixel that fails leaves both surfaces untouched. With this rule a nearer shape drawn first survives a farther shape drawn later over the same area.

The depth-test enable, compare mode, depth-write mask and the two base pointers sit in context registers. These registers keep their values from one rectangle to the next. A rectangle job consists of bounds, colour and depth, and a start strobe launches it. The engine reports a busy level, a one-cycle done pulse and the number of colour writes made by the current job.

Top module: `depth_rect_fill`

## Requirements
- R1: While reset is held and right after it, busy, done, mem_req and pix_count are all 0, and the context resets to test off, mode 0, mask 0 and both bases 0.
- R2: When the test enable is 0, every covered pixel receives the colour, and the depth as well when the mask is 0. A later rectangle overwrites an earlier one (last write wins).
- R3: The compare mode field ctx_cmp_mode is encoded 0 = never pass, 1 = always pass, 2 = pass when the incoming depth is greater than or equal to the stored depth, and 3 = pass when it is strictly greater. Depths compare as unsigned 32-bit values.
- R4: A pixel that fails the test writes neither the colour word nor the depth word.
- R5: When ctx_zmask is 1, no depth word is written. When it is 0, every passing pixel writes fill_depth to its depth word.
- R6: The colour byte address of pixel (x,y) is frame_base*2048 + 4*(y*ROW_PIX + x), and the depth byte address is depth_base*2048 + 4*(y*ROW_PIX + x), both taken modulo 2^ADDR_W. A depth base of 1 therefore starts the depth surface at 0x800.
- R7: The bounds are inclusive: x0..x1 by y0..y1. Pixels are visited with x as the inner loop and y as the outer loop. If x1 < x0 or y1 < y0, the job touches no pixel and still completes.
- R8: A context write is taken only while the engine is idle, and a context write in the same cycle as an accepted start applies to that job. Context values persist across jobs, and a context write while busy is ignored.
- R9: The engine issues at most one memory request per cycle (mem_we only together with mem_req). Each pixel costs one read of its depth word, then one cycle without a request while the registered read data returns, then its writes: colour first, then depth. The next pixel's read comes only after those writes.
- R10: With N pixels, P of them passing and W = 1 if depth writes are enabled (0 otherwise), done is high exactly 2N + P*(1+W) + 1 cycles after the start-accepting edge (after 1 cycle for an empty job). Busy falls in the cycle in which done rises, and a start while busy is ignored.
- R11: pix_count clears when a start is accepted, counts the colour writes of that job, and holds its value after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_wr | input | 1 | Load the context registers (taken only when idle) |
| ctx_test_en | input | 1 | Depth test enable |
| ctx_cmp_mode | input | 2 | Compare mode: 0 never, 1 always, 2 greater-or-equal, 3 greater |
| ctx_zmask | input | 1 | 1 suppresses depth writes |
| ctx_frame_base | input | BASE_W | Colour surface base in 2048-byte units |
| ctx_depth_base | input | BASE_W | Depth surface base in 2048-byte units |
| start | input | 1 | Launch a rectangle job (taken only when idle) |
| rect_x0 | input | COORD_W | Left bound, inclusive |
| rect_y0 | input | COORD_W | Top bound, inclusive |
| rect_x1 | input | COORD_W | Right bound, inclusive |
| rect_y1 | input | COORD_W | Bottom bound, inclusive |
| fill_color | input | DATA_W | Colour written to passing pixels |
| fill_depth | input | DATA_W | Incoming depth for the whole rectangle |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after the read request |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse when a job completes |
| pix_count | output | CNT_W | Colour writes made by the current or last job |

## Verification
Two things can coincide in one cycle. The first is a context write landing on the same cycle as a start, or arriving while a job is running. The second is a new start strobe arriving while a job is still running. The bench sends a context write that changes the mode together with a stray start and a different colour into a running job. It then judges at the memory ports: the image must match a model that ignores both, and the cycle count of the job and pix_count must be unchanged. When the two bases are set equal, the colour write and the depth write of one pixel land on the same word. The bench compares this case against the model, which applies colour first and depth second.

// File: rtl/depth_fill_pkg.sv
package depth_fill_pkg;

    typedef enum logic [1:0] {
        ZCMP_NEVER  = 2'd0,
        ZCMP_ALWAYS = 2'd1,
        ZCMP_GEQ    = 2'd2,
        ZCMP_GT     = 2'd3
    } zcmp_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_READ = 3'd1,
        ST_TEST = 3'd2,
        ST_WCOL = 3'd3,
        ST_WDEP = 3'd4
    } fill_st_e;

    // base pointers count 2048-byte pages
    localparam int unsigned BASE_SHIFT = 11;

endpackage

// File: rtl/depth_cmp.sv
module depth_cmp
    import depth_fill_pkg::*;
#(
    parameter int Z_W = 32
) (
    input  logic           enable_i,
    input  zcmp_e          mode_i,
    input  logic [Z_W-1:0] incoming_i,
    input  logic [Z_W-1:0] stored_i,
    output logic           pass_o
);

    always_comb begin
        if (!enable_i) begin
            pass_o = 1'b1;
        end else begin
            case (mode_i)
                ZCMP_NEVER:  pass_o = 1'b0;
                ZCMP_ALWAYS: pass_o = 1'b1;
                ZCMP_GEQ:    pass_o = (incoming_i >= stored_i);
                ZCMP_GT:     pass_o = (incoming_i >  stored_i);
                default:     pass_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pix_addr.sv
module pix_addr
    import depth_fill_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int COORD_W = 6,
    parameter int ROW_PIX = 16,
    parameter int BASE_W  = 4
) (
    input  logic [BASE_W-1:0]  base_i,
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    output logic [ADDR_W-1:0]  addr_o
);

    localparam int LIN_W  = 2 * COORD_W + $clog2(ROW_PIX) + 1;
    localparam int WIDE_W = ADDR_W + BASE_W + LIN_W + BASE_SHIFT + 4;

    logic [LIN_W-1:0] lin;

    always_comb begin
        lin    = LIN_W'(y_i) * LIN_W'(ROW_PIX) + LIN_W'(x_i);
        addr_o = ADDR_W'((WIDE_W'(base_i) << BASE_SHIFT) + (WIDE_W'(lin) << 2));
    end

endmodule

// File: rtl/depth_rect_fill.sv
module depth_rect_fill
    import depth_fill_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int COORD_W = 6,
    parameter int ROW_PIX = 16,
    parameter int BASE_W  = 4,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctx_wr,
    input  logic               ctx_test_en,
    input  logic [1:0]         ctx_cmp_mode,
    input  logic               ctx_zmask,
    input  logic [BASE_W-1:0]  ctx_frame_base,
    input  logic [BASE_W-1:0]  ctx_depth_base,
    input  logic               start,
    input  logic [COORD_W-1:0] rect_x0,
    input  logic [COORD_W-1:0] rect_y0,
    input  logic [COORD_W-1:0] rect_x1,
    input  logic [COORD_W-1:0] rect_y1,
    input  logic [DATA_W-1:0]  fill_color,
    input  logic [DATA_W-1:0]  fill_depth,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               busy,
    output logic               done,
    output logic [CNT_W-1:0]   pix_count
);

    localparam int NBUF    = 2;
    localparam int BUF_COL = 0;
    localparam int BUF_DEP = 1;

    typedef struct packed {
        fill_st_e            st;
        logic [COORD_W-1:0]  x;
        logic [COORD_W-1:0]  y;
        logic [COORD_W-1:0]  x0;
        logic [COORD_W-1:0]  x1;
        logic [COORD_W-1:0]  y1;
        logic [DATA_W-1:0]   color;
        logic [DATA_W-1:0]   depth;
        logic                test_en;
        zcmp_e               mode;
        logic                zmask;
        logic [BASE_W-1:0]   fbase;
        logic [BASE_W-1:0]   zbase;
        logic                done;
        logic [CNT_W-1:0]    cnt;
    } regs_t;

    regs_t r_q, r_d;

    // per-surface address generators: colour and depth share one layout
    logic [BASE_W-1:0] base_sel [NBUF];
    logic [ADDR_W-1:0] buf_addr [NBUF];

    assign base_sel[BUF_COL] = r_q.fbase;
    assign base_sel[BUF_DEP] = r_q.zbase;

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_addr
            pix_addr #(
                .ADDR_W (ADDR_W),
                .COORD_W(COORD_W),
                .ROW_PIX(ROW_PIX),
                .BASE_W (BASE_W)
            ) i_addr (
                .base_i(base_sel[g]),
                .x_i   (r_q.x),
                .y_i   (r_q.y),
                .addr_o(buf_addr[g])
            );
        end
    endgenerate

    logic z_pass;

    depth_cmp #(.Z_W(DATA_W)) i_cmp (
        .enable_i  (r_q.test_en),
        .mode_i    (r_q.mode),
        .incoming_i(r_q.depth),
        .stored_i  (mem_rdata),
        .pass_o    (z_pass)
    );

    logic step;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        step      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;

        case (r_q.st)
            ST_IDLE: begin
                if (ctx_wr) begin
                    r_d.test_en = ctx_test_en;
                    r_d.mode    = zcmp_e'(ctx_cmp_mode);
                    r_d.zmask   = ctx_zmask;
                    r_d.fbase   = ctx_frame_base;
                    r_d.zbase   = ctx_depth_base;
                end
                if (start) begin
                    r_d.x0    = rect_x0;
                    r_d.x1    = rect_x1;
                    r_d.y1    = rect_y1;
                    r_d.x     = rect_x0;
                    r_d.y     = rect_y0;
                    r_d.color = fill_color;
                    r_d.depth = fill_depth;
                    r_d.cnt   = '0;
                    if ((rect_x1 < rect_x0) || (rect_y1 < rect_y0)) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = ST_READ;
                    end
                end
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = buf_addr[BUF_DEP];
                r_d.st   = ST_TEST;
            end
            ST_TEST: begin
                if (z_pass) begin
                    r_d.st = ST_WCOL;
                end else begin
                    step = 1'b1;
                end
            end
            ST_WCOL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_addr[BUF_COL];
                mem_wdata = r_q.color;
                r_d.cnt   = r_q.cnt + 1'b1;
                if (r_q.zmask) begin
                    step = 1'b1;
                end else begin
                    r_d.st = ST_WDEP;
                end
            end
            ST_WDEP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_addr[BUF_DEP];
                mem_wdata = r_q.depth;
                step      = 1'b1;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        // raster walk: x inner, y outer, inclusive bounds
        if (step) begin
            if (r_q.x == r_q.x1) begin
                if (r_q.y == r_q.y1) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.x  = r_q.x0;
                    r_d.y  = r_q.y + 1'b1;
                    r_d.st = ST_READ;
                end
            end else begin
                r_d.x  = r_q.x + 1'b1;
                r_d.st = ST_READ;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.mode    <= ZCMP_NEVER;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign pix_count = r_q.cnt;

endmodule

// File: rtl/depth_rect_fill_chk.sv
module depth_rect_fill_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic mem_req,
    input logic mem_we
);

    // R10: the end of a job is always flagged by done
    assert_fall_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10: done never coincides with a running job
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: a write is always a request
    assert_we_in_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R9: no memory traffic outside a job
    assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R9: the cycle after a read carries no request (data return slot)
    assert_read_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req);

endmodule

bind depth_rect_fill depth_rect_fill_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .mem_req(mem_req),
    .mem_we (mem_we)
);

// File: tb/test_depth_rect_fill.sv
`timescale 1ns/1ps
module test_depth_rect_fill;

    localparam int AW    = 12;
    localparam int CW    = 6;
    localparam int RP    = 16;
    localparam int BW    = 4;
    localparam int DW    = 32;
    localparam int CNTW  = 16;
    localparam int WORDS = (1 << AW) / 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ctx_wr, ctx_test_en, ctx_zmask;
    logic [1:0]    ctx_cmp_mode;
    logic [BW-1:0] ctx_frame_base, ctx_depth_base;
    logic          start;
    logic [CW-1:0] rect_x0, rect_y0, rect_x1, rect_y1;
    logic [DW-1:0] fill_color, fill_depth;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          busy, done;
    logic [CNTW-1:0] pix_count;

    always #2.5 clk = ~clk;

    depth_rect_fill #(
        .ADDR_W(AW), .COORD_W(CW), .ROW_PIX(RP), .BASE_W(BW), .DATA_W(DW), .CNT_W(CNTW)
    ) i_depth_rect_fill (
        .clk(clk), .rst_n(rst_n),
        .ctx_wr(ctx_wr), .ctx_test_en(ctx_test_en), .ctx_cmp_mode(ctx_cmp_mode),
        .ctx_zmask(ctx_zmask), .ctx_frame_base(ctx_frame_base), .ctx_depth_base(ctx_depth_base),
        .start(start), .rect_x0(rect_x0), .rect_y0(rect_y0), .rect_x1(rect_x1), .rect_y1(rect_y1),
        .fill_color(fill_color), .fill_depth(fill_depth),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pix_count(pix_count)
    );

    // shared single-port memory, registered read
    logic [DW-1:0] mem [WORDS];
    logic          mem_clear;

    always @(posedge clk) begin
        if (mem_clear) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
            mem_rdata <= '0;
        end else if (mem_req) begin
            if (mem_we) mem[mem_addr[AW-1:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[AW-1:2]];
        end
    end

    // bench model
    logic [DW-1:0] ref_mem [WORDS];
    bit            m_test, m_zm;
    int            m_mode, m_fb, m_zb;
    int            total = 0, bad = 0;
    bit            finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic int widx(input int base, input int x, input int y);
        return ((base * 2048 + 4 * (y * RP + x)) % (1 << AW)) / 4;
    endfunction

    function automatic bit zpass(input bit ten, input int mode,
                                 input logic [31:0] inc, input logic [31:0] sto);
        if (!ten) return 1'b1;
        case (mode)
            0: return 1'b0;
            1: return 1'b1;
            2: return inc >= sto;
            default: return inc > sto;
        endcase
    endfunction

    task automatic set_ctx(input bit ten, input int mode, input bit zm,
                           input int fb, input int zb);
        @(negedge clk);
        ctx_wr = 1'b1; ctx_test_en = ten; ctx_cmp_mode = 2'(mode);
        ctx_zmask = zm; ctx_frame_base = BW'(fb); ctx_depth_base = BW'(zb);
        @(negedge clk);
        ctx_wr = 1'b0;
        m_test = ten; m_mode = mode; m_zm = zm; m_fb = fb; m_zb = zb;
    endtask

    task automatic mem_cmp(input string req);
        int mism = 0, fi = 0;
        for (int i = 0; i < WORDS; i++)
            if (mem[i] !== ref_mem[i]) begin
                if (mism == 0) fi = i;
                mism++;
            end
        chk(mism == 0, req, $sformatf("memory word %0d (%0d diffs)", fi, mism),
            mem[fi], ref_mem[fi]);
    endtask

    // runs one job, checks latency, pix_count and the whole memory image
    task automatic run_prim(input int x0, input int y0, input int x1, input int y1,
                            input logic [31:0] col, input logic [31:0] dep,
                            input string req, input bit poke);
        int writes = 0, cycles = 0, n;
        for (int y = y0; y <= y1; y++)
            for (int x = x0; x <= x1; x++) begin
                cycles += 2;
                if (zpass(m_test, m_mode, dep, ref_mem[widx(m_zb, x, y)])) begin
                    ref_mem[widx(m_fb, x, y)] = col;
                    writes++;
                    cycles++;
                    if (!m_zm) begin
                        ref_mem[widx(m_zb, x, y)] = dep;
                        cycles++;
                    end
                end
            end
        @(negedge clk);
        start = 1'b1;
        rect_x0 = CW'(x0); rect_y0 = CW'(y0); rect_x1 = CW'(x1); rect_y1 = CW'(y1);
        fill_color = col; fill_depth = dep;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 20000) begin
            if (poke && n == 3) begin
                start = 1'b1; fill_color = ~col; fill_depth = ~dep;
                rect_x0 = '0; rect_x1 = CW'(RP - 1);
                ctx_wr = 1'b1; ctx_test_en = 1'b1; ctx_cmp_mode = 2'd0;
                ctx_zmask = ~m_zm; ctx_frame_base = BW'(m_zb);
            end else begin
                start = 1'b0; ctx_wr = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0; ctx_wr = 1'b0;
        chk(n == cycles + 1, "R10", {"done latency ", req}, n, cycles + 1);
        chk(pix_count == CNTW'(writes), "R11", {"pix_count ", req}, pix_count, writes);
        mem_cmp(req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; mem_clear = 1'b1; start = 1'b0; ctx_wr = 1'b0;
        ctx_test_en = 1'b0; ctx_cmp_mode = 2'd0; ctx_zmask = 1'b0;
        ctx_frame_base = '0; ctx_depth_base = '0;
        rect_x0 = '0; rect_y0 = '0; rect_x1 = '0; rect_y1 = '0;
        fill_color = '0; fill_depth = '0;
        for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
        m_test = 0; m_mode = 0; m_zm = 0; m_fb = 0; m_zb = 0;
        repeat (4) @(negedge clk);
        chk(!busy && !done && !mem_req && pix_count == 0, "R1", "outputs in reset",
            {busy, done, mem_req, |pix_count}, 0);
        rst_n = 1'b1; mem_clear = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_req && pix_count == 0, "R1", "outputs after reset",
            {busy, done, mem_req, |pix_count}, 0);

        // near shape first, then a farther one over it; near must survive
        set_ctx(1, 2, 0, 0, 1);
        run_prim(0, 0, 11, 7, 32'h000000FF, 32'h200, "R3 near", 0);
        chk(mem[32'h800 / 4] == 32'h200, "R6", "depth word at byte 0x800", mem[32'h800 / 4], 32'h200);
        run_prim(4, 0, 15, 7, 32'h00FF0000, 32'h100, "R4 far", 0);
        chk(mem[widx(0, 6, 3)] == 32'h000000FF, "R4", "overlap keeps near colour",
            mem[widx(0, 6, 3)], 32'h000000FF);
        chk(mem[widx(0, 13, 5)] == 32'h00FF0000, "R3", "far-only colour",
            mem[widx(0, 13, 5)], 32'h00FF0000);

        // equal depth: greater fails, greater-or-equal passes
        set_ctx(1, 3, 0, 0, 1);
        run_prim(0, 0, 3, 0, 32'h0000FF00, 32'h200, "R3 gt equal", 0);
        chk(pix_count == 0, "R3", "strict greater rejects equal", pix_count, 0);
        set_ctx(1, 2, 0, 0, 1);
        run_prim(0, 0, 3, 0, 32'h0000FF00, 32'h200, "R3 geq equal", 0);
        set_ctx(1, 0, 0, 0, 1);
        run_prim(0, 0, 15, 7, 32'hDEADBEEF, 32'hFFFFFFFF, "R3 never", 0);

        // test disabled: blind overwrite with a lower depth
        set_ctx(0, 0, 0, 0, 1);
        run_prim(2, 1, 9, 4, 32'h12345678, 32'h5, "R2 test off", 0);
        chk(mem[widx(1, 2, 1)] == 32'h5, "R2", "depth overwritten", mem[widx(1, 2, 1)], 32'h5);

        // depth writes masked
        set_ctx(1, 1, 1, 0, 1);
        run_prim(0, 0, 5, 2, 32'hCAFE0001, 32'h77, "R5 masked", 0);
        chk(mem[widx(1, 0, 0)] != 32'h77, "R5", "masked depth unchanged", mem[widx(1, 0, 0)], 0);

        // persistence: second job without reprogramming
        run_prim(6, 3, 8, 6, 32'hCAFE0002, 32'h88, "R8 persist", 0);

        // empty and single-pixel rectangles
        run_prim(5, 0, 4, 3, 32'h1, 32'h1, "R7 empty x", 0);
        run_prim(0, 6, 3, 5, 32'h1, 32'h1, "R7 empty y", 0);
        set_ctx(1, 3, 0, 0, 1);
        run_prim(15, 7, 15, 7, 32'hABCDEF01, 32'hFFFF0000, "R7 single", 0);
        chk(mem[widx(0, 15, 7)] == 32'hABCDEF01, "R7", "corner pixel", mem[widx(0, 15, 7)], 32'hABCDEF01);

        // surfaces swapped
        set_ctx(1, 1, 0, 1, 0);
        run_prim(1, 1, 4, 2, 32'h0F0F0F0F, 32'h3, "R6 swapped", 0);

        // stray start and context write during a job
        set_ctx(1, 2, 0, 0, 1);
        run_prim(0, 0, 3, 1, 32'h55AA55AA, 32'hFFFFFFF0, "R8 R10 poke", 1);
        run_prim(0, 2, 1, 2, 32'h66, 32'hFFFFFFF1, "R8 context kept", 0);

        // constrained random
        for (int k = 0; k < 40; k++) begin
            int xa, xb, ya, yb;
            logic [31:0] dp;
            if (k % 2 == 0)
                set_ctx(1'($urandom_range(0, 3) != 0), $urandom_range(0, 3),
                        1'($urandom_range(0, 3) == 0), $urandom_range(0, 1), $urandom_range(0, 1));
            xa = $urandom_range(0, RP - 1); xb = $urandom_range(0, RP - 1);
            ya = $urandom_range(0, 7);      yb = $urandom_range(0, 7);
            if ($urandom_range(0, 7) != 0) begin
                if (xb < xa) begin int t = xa; xa = xb; xb = t; end
                if (yb < ya) begin int t = ya; ya = yb; yb = t; end
            end
            dp = ($urandom_range(0, 3) == 0) ? $urandom() : 32'($urandom_range(0, 3)) << 8;
            run_prim(xa, ya, xb, yb, $urandom(), dp, "R2 R3 R4 R5 R6 R7 random", 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #900000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R10 act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule